// File: doc/BRIEF.md
# Two-Vector Delay Test Sequencer over a Scan Chain

This block wraps a combinational logic cone between two banks of mux-D scan flip-flops: a launch bank that drives the cone and a capture bank that samples its response. A small controller runs a complete two-vector delay test without outside help. It first shifts an initialization vector into the chain serially. It then applies the launch edge, which creates the second vector, and one clock later the capture edge, which samples the cone's response. Last, it shifts the whole chain out. While no test is running, the flip-flops behave as ordinary functional registers.

The second vector can be made in one of two ways, and a mode input picks which. In shift-launch mode the launch edge is one more scan shift, so the second vector is the first one moved along by one bit. In capture-launch mode the launch edge is a functional load, so the second vector is whatever the upstream logic presents at that moment. While a response is shifted out, the next initialization vector can be shifted in. A start issued after completion then goes straight to the launch edge.

Top module: `dly2v_scan_seq`

## Requirements
- R1: While idle, scan_en_o is low and every flip-flop loads its functional input each clock. launch_q_o equals up_data_i and capture_q_o equals dn_data_i one clock later.
- R2: The serial chain runs from scan_in_i into launch bit 0, up to launch bit LW-1, then into capture bit 0, up to capture bit CW-1, which drives scan_out_o. Each shift moves every bit one position toward scan_out_o.
- R3: A start in idle is followed by LW+CW shift cycles with scan_en_o high. The first bit presented ends in capture bit CW-1, and the last bit presented ends in launch bit 0.
- R4: In shift-launch mode (mode_i = 0), scan_en_o is high during the launch cycle and low during the capture cycle. After the launch edge, launch_q_o equals the loaded vector shifted one position toward the MSB, with scan_in_i entering bit 0.
- R5: In capture-launch mode (mode_i = 1), scan_en_o is low during both the launch cycle and the capture cycle. The launch edge loads up_data_i into launch_q_o.
- R6: The capture edge comes one clock after the launch edge and loads dn_data_i into capture_q_o. The launch bank holds its value at the capture edge.
- R7: After the capture edge, LW+CW unload cycles follow with scan_en_o high. scan_out_o presents capture bit CW-1 first, and the bits shifted in through scan_in_i at the same time form the next vector.
- R8: After the last unload shift, done_o stays high and both banks hold their values until the next start.
- R9: A start while done_o is high skips the serial load. It goes directly to the launch cycle and uses the vector that was shifted in during the unload.
- R10: A start during a test is ignored. mode_i is sampled only on an accepted start.
- R11: After reset, the sequencer is idle with done_o and scan_en_o low and both banks cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; launch and capture edges are consecutive rising edges |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to run a test |
| mode_i | input | 1 | 0 selects shift-launch, 1 selects capture-launch |
| scan_in_i | input | 1 | Serial data into launch bit 0 |
| scan_out_o | output | 1 | Serial data from capture bit CW-1 |
| scan_en_o | output | 1 | Scan-enable driven by the sequencer to every flip-flop mux |
| done_o | output | 1 | High while a finished test waits for a new start |
| up_data_i | input | LW | Upstream logic output, the functional input of the launch bank |
| launch_q_o | output | LW | Launch bank contents, driving the cone under test |
| dn_data_i | input | CW | Cone response, the functional input of the capture bank |
| capture_q_o | output | CW | Capture bank contents |

## Verification
A start accepted at a rising edge puts the first shift cycle in the following clock, and the launch cycle starts LW+CW clocks later. The launch bank shows the second vector one clock after that, and the capture bank shows the response one clock later again. done_o rises LW+CW clocks after the capture edge. A start from done instead puts the launch cycle in the very next clock. The bench drives inputs at falling edges and samples at falling edges, stepping exactly one clock per state. Each value is therefore read in the half-cycle after the register that produces it has updated, and no sample depends on process order at the rising edge.

// File: rtl/dts_pkg.sv
// Shared types for the two-vector delay test sequencer.
package dts_pkg;

    // Controller phases, in the order a test from idle visits them.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOAD    = 3'd1,
        ST_LAUNCH  = 3'd2,
        ST_CAPTURE = 3'd3,
        ST_UNLOAD  = 3'd4,
        ST_HOLD    = 3'd5
    } dts_state_e;

    // Way the second vector is generated.
    typedef enum logic {
        LM_SHIFT = 1'b0,
        LM_FUNC  = 1'b1
    } dts_mode_e;

endpackage

// File: rtl/dts_scan_reg.sv
// Bank of W mux-D scan flip-flops.
// Each bit selects its serial neighbour when se is high and its functional
// input otherwise. Bit 0 takes si, and bit i takes bit i-1. en low holds the
// whole bank. Assumes a synchronous active-low reset.
module dts_scan_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         se,
    input  logic         si,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar g = 0; g < W; g++) begin : g_cell
        logic ser_d;
        logic bit_q;

        if (g == 0) begin : g_head
            assign ser_d = si;
        end else begin : g_link
            assign ser_d = q[g-1];
        end

        // One scan cell: the mux in front of D, then the flop.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (en)
                bit_q <= se ? ser_d : d[g];
        end

        assign q[g] = bit_q;
    end

endmodule

// File: rtl/dts_ctrl.sv
// Sequencer for a two-vector delay test.
// From idle it goes: load (TOT shifts), launch, capture, unload (TOT shifts),
// hold. A start in hold goes straight to launch. The mode is latched on each
// accepted start. Assumes TOT >= 2 and a synchronous active-low reset.
module dts_ctrl
    import dts_pkg::*;
#(
    parameter int TOT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       mode_i,
    output logic       se_o,
    output logic       en_launch_o,
    output logic       en_cap_o,
    output logic       done_o,
    output dts_state_e st_o,
    output dts_mode_e  mode_o
);

    localparam int CNT_W = $clog2(TOT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOT - 1);

    dts_state_e       st_q;
    dts_mode_e        mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_last;

    assign cnt_last = (cnt_q == CNT_LAST);

    // Phase register, shift counter and latched mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            mode_q <= LM_SHIFT;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q   <= ST_LOAD;
                        cnt_q  <= '0;
                        mode_q <= dts_mode_e'(mode_i);
                    end
                end
                ST_LOAD: begin
                    if (cnt_last) begin
                        st_q  <= ST_LAUNCH;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_LAUNCH:  st_q <= ST_CAPTURE;
                ST_CAPTURE: begin
                    st_q  <= ST_UNLOAD;
                    cnt_q <= '0;
                end
                ST_UNLOAD: begin
                    if (cnt_last) begin
                        st_q  <= ST_HOLD;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (start_i) begin
                        st_q   <= ST_LAUNCH;
                        mode_q <= dts_mode_e'(mode_i);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Per-phase scan-enable and bank enables.
    always_comb begin
        se_o        = 1'b0;
        en_launch_o = 1'b1;
        en_cap_o    = 1'b1;
        case (st_q)
            ST_LOAD, ST_UNLOAD: se_o = 1'b1;
            ST_LAUNCH: begin
                se_o     = (mode_q == LM_SHIFT);
                en_cap_o = 1'b0;
            end
            ST_CAPTURE: en_launch_o = 1'b0;
            ST_HOLD: begin
                en_launch_o = 1'b0;
                en_cap_o    = 1'b0;
            end
            default: ;
        endcase
    end

    assign done_o = (st_q == ST_HOLD);
    assign st_o   = st_q;
    assign mode_o = mode_q;

endmodule

// File: rtl/dly2v_scan_seq.sv
// Two-vector delay test sequencer: a launch bank and a capture bank of scan
// flip-flops joined into one serial chain, run by dts_ctrl. The cone under
// test sits outside, between launch_q_o and dn_data_i. Assumes LW, CW >= 2.
module dly2v_scan_seq
    import dts_pkg::*;
#(
    parameter int LW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic          scan_in_i,
    output logic          scan_out_o,
    output logic          scan_en_o,
    output logic          done_o,
    input  logic [LW-1:0] up_data_i,
    output logic [LW-1:0] launch_q_o,
    input  logic [CW-1:0] dn_data_i,
    output logic [CW-1:0] capture_q_o
);

    localparam int TOT = LW + CW;

    logic       se_w;
    logic       en_l_w;
    logic       en_c_w;
    dts_state_e st_w;
    dts_mode_e  mode_q_w;

    dts_ctrl #(.TOT(TOT)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .se_o        (se_w),
        .en_launch_o (en_l_w),
        .en_cap_o    (en_c_w),
        .done_o      (done_o),
        .st_o        (st_w),
        .mode_o      (mode_q_w)
    );

    dts_scan_reg #(.W(LW)) u_launch (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_l_w),
        .se    (se_w),
        .si    (scan_in_i),
        .d     (up_data_i),
        .q     (launch_q_o)
    );

    dts_scan_reg #(.W(CW)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_c_w),
        .se    (se_w),
        .si    (launch_q_o[LW-1]),
        .d     (dn_data_i),
        .q     (capture_q_o)
    );

    assign scan_en_o  = se_w;
    assign scan_out_o = capture_q_o[CW-1];

endmodule

// File: rtl/dly2v_scan_seq_chk.sv
// Property checker for dly2v_scan_seq, attached by the bind at the end.
module dly2v_scan_seq_chk
    import dts_pkg::*;
#(
    parameter int LW = 8,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          scan_in_i,
    input logic          scan_en_o,
    input logic          done_o,
    input logic [LW-1:0] up_data_i,
    input logic [LW-1:0] launch_q_o,
    input logic [CW-1:0] dn_data_i,
    input logic [CW-1:0] capture_q_o,
    input logic [2:0]    st,
    input logic          mode_q
);

    // R1: mission mode loads the functional inputs.
    p_mission_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> (launch_q_o == $past(up_data_i)) && (capture_q_o == $past(dn_data_i)));

    // R2: a scan-enabled edge shifts the launch bank by one position.
    p_shift_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en_o |=> launch_q_o == {$past(launch_q_o[LW-2:0]), $past(scan_in_i)});

    // R4: shift-launch keeps scan-enable high on launch, low on capture.
    p_los_se_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LAUNCH && mode_q == LM_SHIFT) |-> scan_en_o ##1 !scan_en_o);

    // R5: capture-launch keeps scan-enable low and loads the upstream value.
    p_loc_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LAUNCH && mode_q == LM_FUNC) |-> !scan_en_o ##1 (!scan_en_o && launch_q_o == $past(up_data_i)));

    // R6: the capture edge samples the cone; the launch bank holds.
    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CAPTURE) |=> (capture_q_o == $past(dn_data_i)) && $stable(launch_q_o));

    // R8: banks hold while done waits without a start.
    p_hold_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o && $stable(launch_q_o) && $stable(capture_q_o));

    // R10: a start during capture cannot divert the unload.
    p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CAPTURE) |=> (st == ST_UNLOAD));

    // R11: scan-enable and done are never high together.
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_en_o && done_o));

endmodule

bind dly2v_scan_seq dly2v_scan_seq_chk #(.LW(LW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .scan_in_i   (scan_in_i),
    .scan_en_o   (scan_en_o),
    .done_o      (done_o),
    .up_data_i   (up_data_i),
    .launch_q_o  (launch_q_o),
    .dn_data_i   (dn_data_i),
    .capture_q_o (capture_q_o),
    .st          (st_w),
    .mode_q      (mode_q_w)
);

// File: tb/test_dly2v_scan_seq.sv
`timescale 1ns/1ps
module test_dly2v_scan_seq;

    localparam int LW  = 8;
    localparam int CW  = 8;
    localparam int TOT = LW + CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic          scan_in_i = 1'b0;
    logic          scan_out_o;
    logic          scan_en_o;
    logic          done_o;
    logic [LW-1:0] up_data_i = '0;
    logic [LW-1:0] launch_q_o;
    logic [CW-1:0] dn_data_i;
    logic [CW-1:0] capture_q_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    // Example cone under test.
    function automatic logic [7:0] cone(input logic [7:0] x);
        return (x + 8'h35) ^ {x[0], x[7:1]};
    endfunction

    assign dn_data_i = cone(launch_q_o);

    dly2v_scan_seq #(.LW(LW), .CW(CW)) i_dly2v_scan_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .scan_in_i(scan_in_i), .scan_out_o(scan_out_o), .scan_en_o(scan_en_o),
        .done_o(done_o), .up_data_i(up_data_i), .launch_q_o(launch_q_o),
        .dn_data_i(dn_data_i), .capture_q_o(capture_q_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 done", done_o, 0);
        chk("R11 scan_en", scan_en_o, 0);
        chk("R11 launch", launch_q_o, 0);
        chk("R11 capture", capture_q_o, 0);
        chk("R11 scan_out", scan_out_o, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_mission(input logic [7:0] val);
        up_data_i = val;
        @(negedge clk);
        chk("R1 launch", launch_q_o, val);
        chk("R1 scan_en", scan_en_o, 0);
        @(negedge clk);
        chk("R1 capture", capture_q_o, cone(val));
    endtask

    // One full test. from_done skips the serial load (R9); poke issues a
    // stray start and flips mode_i during the load (R10).
    task automatic t_run(input logic mode, input logic [7:0] v1, input logic [7:0] v1n,
                         input logic lb, input logic [7:0] upv, input bit from_done,
                         input bit poke);
        logic [TOT-1:0] tgt;
        logic [TOT-1:0] ntgt;
        logic [TOT-1:0] chain;
        logic [7:0]     v2;
        int             bad;
        tgt  = {8'hC3, v1};
        ntgt = {8'h5C, v1n};
        up_data_i = upv;
        start_i = 1'b1;
        mode_i  = mode;
        @(negedge clk);
        start_i = 1'b0;
        if (!from_done) begin
            bad = 0;
            for (int j = 0; j < TOT; j++) begin
                scan_in_i = tgt[TOT-1-j];
                if (scan_en_o !== 1'b1) bad++;
                if (poke && j == 3) begin
                    start_i = 1'b1;
                    mode_i  = ~mode;
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
            end
            chk("R3 scan_en during load", bad, 0);
            chk("R2 capture after load", capture_q_o, tgt[TOT-1:LW]);
        end else begin
            chk("R9 done drops", done_o, 0);
        end
        chk(from_done ? "R9 launch holds V1" : "R3 launch holds V1", launch_q_o, v1);
        chk(mode ? "R5 scan_en launch" : "R4 scan_en launch", scan_en_o, mode ? 0 : 1);
        scan_in_i = lb;
        @(negedge clk);
        v2 = mode ? upv : {v1[6:0], lb};
        chk(mode ? "R5 V2" : "R4 V2 shift", launch_q_o, v2);
        chk(mode ? "R5 scan_en capture" : "R4 scan_en capture", scan_en_o, 0);
        @(negedge clk);
        chk("R6 capture", capture_q_o, cone(v2));
        chk("R6 launch hold", launch_q_o, v2);
        chain = {cone(v2), v2};
        bad = 0;
        for (int j = 0; j < TOT; j++) begin
            if (scan_out_o !== chain[TOT-1-j]) bad++;
            if (done_o !== 1'b0) bad++;
            scan_in_i = ntgt[TOT-1-j];
            @(negedge clk);
        end
        chk("R7 unload stream", bad, 0);
        chk("R8 done", done_o, 1);
        chk("R7 next V1", launch_q_o, v1n);
        chk("R2 capture after unload", capture_q_o, ntgt[TOT-1:LW]);
        up_data_i = ~upv;
        scan_in_i = ~scan_in_i;
        repeat (3) @(negedge clk);
        chk("R8 hold launch", launch_q_o, v1n);
        chk("R8 hold capture", capture_q_o, ntgt[TOT-1:LW]);
        chk("R8 done stays", done_o, 1);
        mode_i = mode;
    endtask

    initial begin
        do_reset();
        t_mission(8'h6B);
        t_mission(8'hF0);
        t_run(1'b0, 8'hA5, 8'h3E, 1'b1, 8'h0F, 1'b0, 1'b0);
        t_run(1'b1, 8'h3E, 8'hD2, 1'b0, 8'h96, 1'b1, 1'b0);
        do_reset();
        t_run(1'b1, 8'h81, 8'h47, 1'b1, 8'h2C, 1'b0, 1'b1);
        t_run(1'b0, 8'h47, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule